// File: doc/BRIEF.md
# Two-Channel Framebuffer Fill Engine

This block paints a rectangle of memory with one repeated pixel value, without a processor writing each word. It holds two fill channels that share one write port toward memory. Software programs a channel through a small register port: a start and an end location, each held as the byte address divided by eight, a fill value, and a control word. The control word picks the pixel width and carries a go bit. The go bit stays high while the channel works and drops when it is done, so software can poll it as a status flag. A one-cycle interrupt on that channel's own line also marks completion.

Each write beat carries one whole pixel, or the part of a pixel that fits in the current 32-bit word. The beat has byte enables that mark exactly the bytes it holds. In the packed three-byte mode a pixel can straddle two words, and it is then sent as two beats. The channels take turns on the memory port by round-robin. A beat waits, held steady, for as long as memory keeps its ready input low.

Top module: `fill_engine`

## Requirements
- R1: After reset every register of both channels reads zero, `mem_valid` is low and both `irq` bits are low.
- R2: The byte range written is from `start_reg*8` up to, but not including, `end_reg*8`. No byte outside it changes, including bytes of a three-byte pixel that would pass the end.
- R3: A write to the control register (index 3) with bit 0 set starts the channel. Bit 0 then reads 1 until the fill ends and reads 0 afterwards.
- R4: Control bit 8 set selects the three-byte mode, whatever bit 9 holds. Otherwise bit 9 set selects the four-byte mode, and with both bits clear the mode is two bytes. Bits 8 and 9 read back as written.
- R5: In two-byte mode, bytes at even addresses get value bits 7:0 and bytes at odd addresses get bits 15:8.
- R6: In four-byte mode, the byte at offset k (modulo 4) from a word boundary gets value bits 8k+7:8k.
- R7: In three-byte mode, each pixel puts value bits 23:16 at its lowest address, then bits 15:8, then bits 7:0. Pixels pack back to back from the start address.
- R8: A go request while the start register holds zero performs no write and raises no interrupt, and bit 0 reads 0.
- R9: When a fill ends, that channel's own `irq` bit is high for exactly one cycle.
- R10: While `mem_valid` is high and `mem_ready` is low, the next cycle keeps `mem_valid` high with `mem_addr`, `mem_be` and `mem_wdata` unchanged.
- R11: Every register write to a busy channel is ignored, including a second go request.
- R12: When both channels have beats pending, accepted beats alternate between the channels.
- R13: `mem_addr` is word aligned. `mem_be` is never zero and covers only the bytes of one pixel. A three-byte pixel that crosses a word boundary goes out as two beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Bit 2 selects the channel; bits 1:0 select start (0), end (1), value (2), control (3) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by `reg_addr` |
| mem_valid | output | 1 | A write beat is offered |
| mem_ready | input | 1 | Memory accepts the beat in this cycle |
| mem_addr | output | ADDR_W | Word-aligned byte address of the beat |
| mem_be | output | 4 | Byte enables, bit n for byte lane n |
| mem_wdata | output | 32 | Beat data, lane n in bits 8n+7:8n |
| irq | output | 2 | Per-channel completion pulse |

## Verification
The bench builds the engine with the default 32-bit address width. It runs a small model memory of 1024 bytes, so every fill region and its guard bytes fit inside that window. It exercises all three pixel widths, including a three-byte fill whose last pixel is cut off by the end address. It also runs both channels at once, with memory ready driven high, low and pseudo-randomly, which covers stalls, arbitration alternation and the one-beat head start of the channel triggered first.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int LANES = 4;
  localparam int CH_N  = 2;

  typedef enum logic [1:0] {FILL16 = 2'd0, FILL24 = 2'd1, FILL32 = 2'd2} fill_mode_e;

  typedef struct packed {
    logic [LANES-1:0]   be;
    logic [8*LANES-1:0] data;
    logic [2:0]         nbytes;
  } beat_t;

  // bit 8 wins over bit 9
  function automatic fill_mode_e decode_mode(logic sel24, logic sel32);
    if (sel24) return FILL24;
    if (sel32) return FILL32;
    return FILL16;
  endfunction

  // One beat: bytes from lane0 up to the nearest of word end, pixel end, fill end.
  function automatic beat_t plan_beat(fill_mode_e mode, logic [1:0] lane0,
                                      logic [1:0] phase, logic [2:0] cap,
                                      logic [31:0] val);
    beat_t b;
    int n, pix, off;
    b = '0;
    case (mode)
      FILL16:  pix = 2;
      FILL32:  pix = 4;
      default: pix = 3 - int'(phase);
    endcase
    n = LANES - int'(lane0);
    if (pix < n) n = pix;
    if (int'(cap) < n) n = int'(cap);
    for (int l = 0; l < LANES; l++) begin
      if (l >= int'(lane0) && l < int'(lane0) + n) begin
        b.be[l] = 1'b1;
        off = l - int'(lane0);
        case (mode)
          FILL16:  b.data[8*l +: 8] = val[8*(l%2) +: 8];
          FILL32:  b.data[8*l +: 8] = val[8*l +: 8];
          default: b.data[8*l +: 8] = val[8*(2-(int'(phase)+off)) +: 8];
        endcase
      end
    end
    b.nbytes = 3'(n);
    return b;
  endfunction

  function automatic logic [1:0] next_phase(fill_mode_e mode, logic [1:0] phase,
                                            logic [2:0] nbytes);
    int p;
    if (mode != FILL24) return 2'd0;
    p = int'(phase) + int'(nbytes);
    return (p >= 3) ? 2'd0 : 2'(p);
  endfunction
endpackage

// File: rtl/fe_channel.sv
module fe_channel
  import fe_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        reg_idx,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              req,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [LANES-1:0]  beat_be,
  output logic [31:0]       beat_data,
  input  logic              accept,
  output logic              done_pulse,
  output logic              busy
);
  logic [31:0]       start_q, end_q, value_q;
  logic              sel24_q, sel32_q, busy_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [1:0]        phase_q;

  logic [ADDR_W-1:0] start_b, end_b, remain;
  logic              more;
  logic [2:0]        cap;
  fill_mode_e        mode;
  beat_t             beat;

  assign start_b = ADDR_W'({start_q, 3'b000});
  assign end_b   = ADDR_W'({end_q, 3'b000});
  assign more    = ptr_q < end_b;
  assign remain  = end_b - ptr_q;
  assign cap     = (remain >= ADDR_W'(LANES)) ? 3'(LANES) : remain[2:0];
  assign mode    = decode_mode(sel24_q, sel32_q);
  assign beat    = plan_beat(mode, ptr_q[1:0], phase_q, cap, value_q);

  assign req        = busy_q && more;
  assign done_pulse = busy_q && !more;
  assign busy       = busy_q;
  assign beat_addr  = {ptr_q[ADDR_W-1:2], 2'b00};
  assign beat_be    = beat.be;
  assign beat_data  = beat.data;

  always_comb begin
    case (reg_idx)
      2'd0:    rd_data = start_q;
      2'd1:    rd_data = end_q;
      2'd2:    rd_data = value_q;
      default: rd_data = {22'd0, sel32_q, sel24_q, 7'd0, busy_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      value_q <= '0;
      sel24_q <= 1'b0;
      sel32_q <= 1'b0;
      busy_q  <= 1'b0;
      ptr_q   <= '0;
      phase_q <= '0;
    end else if (!busy_q) begin
      if (wr_en) begin
        case (reg_idx)
          2'd0: start_q <= wr_data;
          2'd1: end_q   <= wr_data;
          2'd2: value_q <= wr_data;
          default: begin
            sel24_q <= wr_data[8];
            sel32_q <= wr_data[9];
            if (wr_data[0] && start_q != '0) begin
              busy_q  <= 1'b1;
              ptr_q   <= start_b;
              phase_q <= 2'd0;
            end
          end
        endcase
      end
    end else begin
      if (!more) busy_q <= 1'b0;
      if (accept) begin
        ptr_q   <= ptr_q + ADDR_W'(beat.nbytes);
        phase_q <= next_phase(mode, phase_q, beat.nbytes);
      end
    end
  end
endmodule

// File: rtl/fe_rr_arb.sv
module fe_rr_arb
  import fe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_N-1:0] req,
  input  logic            ready,
  output logic [CH_N-1:0] gnt
);
  logic            last_q;
  logic            hold_q;
  logic [CH_N-1:0] held_q;

  always_comb begin
    if (hold_q)             gnt = held_q;
    else if (&req)          gnt = last_q ? 2'b01 : 2'b10;
    else                    gnt = req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= 1'b1;
      hold_q <= 1'b0;
      held_q <= '0;
    end else begin
      hold_q <= (|gnt) && !ready;
      held_q <= gnt;
      if ((|gnt) && ready) last_q <= gnt[1];
    end
  end
endmodule

// File: rtl/fill_engine.sv
module fill_engine
  import fe_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  output logic [1:0]        irq
);
  logic [CH_N-1:0]   ch_req, ch_busy, gnt, ch_accept;
  logic [31:0]       ch_rd   [CH_N];
  logic [ADDR_W-1:0] ch_addr [CH_N];
  logic [LANES-1:0]  ch_be   [CH_N];
  logic [31:0]       ch_data [CH_N];

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    assign ch_accept[c] = gnt[c] && mem_ready;
    fe_channel #(.ADDR_W(ADDR_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_we && (reg_addr[2] == 1'(c))),
      .reg_idx   (reg_addr[1:0]),
      .wr_data   (reg_wdata),
      .rd_data   (ch_rd[c]),
      .req       (ch_req[c]),
      .beat_addr (ch_addr[c]),
      .beat_be   (ch_be[c]),
      .beat_data (ch_data[c]),
      .accept    (ch_accept[c]),
      .done_pulse(irq[c]),
      .busy      (ch_busy[c])
    );
  end

  fe_rr_arb u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (ch_req),
    .ready(mem_ready),
    .gnt  (gnt)
  );

  assign reg_rdata = ch_rd[reg_addr[2]];
  assign mem_valid = |ch_req;
  assign mem_addr  = gnt[1] ? ch_addr[1] : ch_addr[0];
  assign mem_be    = gnt[1] ? ch_be[1]   : ch_be[0];
  assign mem_wdata = gnt[1] ? ch_data[1] : ch_data[0];
endmodule

// File: rtl/fill_engine_chk.sv
module fill_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic [1:0]        irq,
  input logic [1:0]        ch_busy,
  input logic [1:0]        gnt
);
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be)
                                && $stable(mem_wdata));

  p_irq0_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |=> !irq[0] && !ch_busy[0]);

  p_irq1_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] |=> !irq[1] && !ch_busy[1]);

  p_beat_shape_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_be != 4'b0000 && mem_addr[1:0] == 2'b00);

  p_grant_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && (mem_valid == (gnt != 2'b00)));

  p_grant_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~ch_busy) == 2'b00);
endmodule

bind fill_engine fill_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_valid(mem_valid),
  .mem_ready(mem_ready),
  .mem_addr (mem_addr),
  .mem_be   (mem_be),
  .mem_wdata(mem_wdata),
  .irq      (irq),
  .ch_busy  (ch_busy),
  .gnt      (gnt)
);

// File: tb/fill_engine_test.sv
module fill_engine_test;
  localparam int PERIOD = 10;
  localparam int MEM_N  = 1024;
  // {ch, bit9, bit8, start, end, value}
  localparam logic [50:0] VEC [6] = '{
    {1'b0, 2'b00, 8'h10, 8'h14, 32'h1234BEEF},
    {1'b1, 2'b10, 8'h20, 8'h23, 32'hDEADC0DE},
    {1'b0, 2'b01, 8'h30, 8'h33, 32'h00A1B2C3},
    {1'b1, 2'b11, 8'h40, 8'h41, 32'h00112233},
    {1'b0, 2'b01, 8'h50, 8'h52, 32'h55667788},
    {1'b1, 2'b00, 8'h60, 8'h61, 32'hFFFF0102}
  };

  logic clk = 0, rst_n = 0, reg_we = 0, mem_ready = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, mem_wdata;
  logic mem_valid;
  logic [31:0] mem_addr;
  logic [3:0] mem_be;
  logic [1:0] irq;

  fill_engine uut (.*);

  always #(PERIOD/2) clk = ~clk;

  int chk_n = 0, fail_n = 0;
  logic [7:0] mem [MEM_N];
  int acc_n = 0;
  logic [3:0]  acc_be   [1024];
  logic [31:0] acc_addr [1024];
  int irq_cnt [2] = '{0, 0};
  int irq_run [2] = '{0, 0};
  int irq_max = 0;
  int ready_mode = 1;
  logic [7:0] lfsr = 8'h5B;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    chk_n++;
    if (!ok) begin
      fail_n++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_valid && mem_ready) begin
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) mem[(mem_addr + l) % MEM_N] = mem_wdata[8*l +: 8];
      if (acc_n < 1024) begin
        acc_be[acc_n] = mem_be;
        acc_addr[acc_n] = mem_addr;
      end
      acc_n++;
    end
    for (int c = 0; c < 2; c++) begin
      if (irq[c]) begin
        irq_cnt[c]++;
        irq_run[c]++;
        if (irq_run[c] > irq_max) irq_max = irq_run[c];
      end else irq_run[c] = 0;
    end
  end

  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = (ready_mode == 1) ? 1'b1 : (ready_mode == 0) ? 1'b0 : lfsr[0];
  end

  initial begin
    #(PERIOD * 150000);
    fail_n++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", chk_n, fail_n);
    $finish;
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_irq(input int c, input int target);
    for (int i = 0; i < 4000 && irq_cnt[c] < target; i++) step();
  endtask

  task automatic clear_mem(input int lo, input int hi);
    for (int a = lo; a < hi; a++) mem[a] = 8'h5A;
  endtask

  function automatic logic [7:0] exp_byte(input logic b9, input logic b8,
                                          input int k, input logic [31:0] v);
    if (b8) return (k % 3 == 0) ? v[23:16] : (k % 3 == 1) ? v[15:8] : v[7:0];
    if (b9) return v[8*(k%4) +: 8];
    return v[8*(k%2) +: 8];
  endfunction

  initial begin
    logic [31:0] d, a0;
    int bad, base, n0, c0;
    logic all0;
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'h5A;
    step(3);
    rst_n = 1;
    step();
    // R1 reset state
    all0 = 1;
    for (int r = 0; r < 8; r++) begin rd(3'(r), d); if (d != 0) all0 = 0; end
    chk(all0 && !mem_valid && irq == 0, "R1 reset state", {29'd0, all0, mem_valid, |irq}, 32'h4);

    // vector walk: R2 R4 R5 R6 R7 R3
    ready_mode = 2;
    for (int i = 0; i < 6; i++) begin
      logic ch, b9, b8; logic [7:0] st, en; logic [31:0] val; int s, e, tgt;
      {ch, b9, b8, st, en, val} = VEC[i];
      s = int'(st) * 8; e = int'(en) * 8;
      clear_mem(s - 8, e + 8);
      tgt = irq_cnt[ch] + 1;
      wr({ch, 2'd0}, {24'd0, st});
      wr({ch, 2'd1}, {24'd0, en});
      wr({ch, 2'd2}, val);
      wr({ch, 2'd3}, {22'd0, b9, b8, 8'h01});
      wait_irq(int'(ch), tgt);
      step(2);
      bad = 0;
      for (int a = s - 8; a < e + 8; a++)
        if (mem[a] != ((a >= s && a < e) ? exp_byte(b9, b8, a - s, val) : 8'h5A)) bad++;
      chk(bad == 0, $sformatf("R2/R5/R6/R7 vector %0d content (R4 mode)", i), bad, 0);
      rd({ch, 2'd3}, d);
      chk(d == {22'd0, b9, b8, 8'h00}, $sformatf("R3 R4 vector %0d control readback", i),
          d, {22'd0, b9, b8, 8'h00});
    end

    // R8 start register zero
    ready_mode = 1;
    n0 = acc_n; c0 = irq_cnt[0];
    wr(3'd0, 32'd0); wr(3'd1, 32'h14); wr(3'd3, 32'h1);
    step(20);
    rd(3'd3, d);
    chk(acc_n == n0 && irq_cnt[0] == c0 && d[0] == 0, "R8 zero start no fill",
        acc_n - n0, 0);

    // R7 R13 R2 three-byte split beats, truncated at end
    clear_mem(16'h78, 16'h90);
    base = acc_n;
    wr(3'd4, 32'h10); wr(3'd5, 32'h11); wr(3'd6, 32'h00AABBCC);
    wr(3'd7, 32'h101);
    wait_irq(1, irq_cnt[1] + 1);
    step(2);
    chk(acc_n - base == 4, "R13 beat count", acc_n - base, 4);
    chk({acc_be[base], acc_be[base+1], acc_be[base+2], acc_be[base+3]} == 16'h783C,
        "R13 byte enables", {16'd0, acc_be[base], acc_be[base+1], acc_be[base+2], acc_be[base+3]},
        32'h783C);
    chk(acc_addr[base] == 32'h80 && acc_addr[base+1] == 32'h80 && acc_addr[base+2] == 32'h84
        && acc_addr[base+3] == 32'h84, "R13 beat addresses", acc_addr[base+2], 32'h84);
    chk({mem[128], mem[129], mem[130], mem[131]} == 32'hAABBCCAA, "R7 bytes 0-3",
        {mem[128], mem[129], mem[130], mem[131]}, 32'hAABBCCAA);
    chk({mem[132], mem[133], mem[134], mem[135]} == 32'hBBCCAABB, "R7 bytes 4-7",
        {mem[132], mem[133], mem[134], mem[135]}, 32'hBBCCAABB);
    chk(mem[136] == 8'h5A && mem[127] == 8'h5A, "R2 no write past end", mem[136], 32'h5A);

    // R10 stall, R11 busy ignore, R3 busy flag
    clear_mem(16'hF8, 16'h118);
    ready_mode = 0;
    c0 = irq_cnt[0];
    wr(3'd0, 32'h20); wr(3'd1, 32'h22); wr(3'd2, 32'h11111111);
    wr(3'd3, 32'h201);
    step(); @(negedge clk); a0 = mem_addr; n0 = acc_n;
    step(5); @(negedge clk);
    chk(mem_valid && mem_addr == a0 && acc_n == n0 && mem_be == 4'hF, "R10 stall holds beat",
        mem_addr, a0);
    step();
    rd(3'd3, d);
    chk(d[0] == 1'b1, "R3 busy reads 1", d, 32'h201);
    wr(3'd2, 32'h22222222);
    wr(3'd3, 32'h001);
    rd(3'd2, d);
    chk(d == 32'h11111111, "R11 value write ignored while busy", d, 32'h11111111);
    rd(3'd3, d);
    chk(d == 32'h201, "R11 control write ignored while busy", d, 32'h201);
    ready_mode = 1;
    wait_irq(0, c0 + 1);
    step(20);
    bad = 0;
    for (int a = 256; a < 272; a++) if (mem[a] != 8'h11) bad++;
    chk(bad == 0 && mem[272] == 8'h5A, "R11 fill used original value", bad, 0);
    chk(irq_cnt[0] == c0 + 1, "R11 second trigger ignored", irq_cnt[0], c0 + 1);

    // R12 round-robin
    clear_mem(16'h380, 16'h3B8);
    base = acc_n;
    wr(3'd0, 32'h70); wr(3'd1, 32'h72); wr(3'd2, 32'h01010101);
    wr(3'd4, 32'h74); wr(3'd5, 32'h76); wr(3'd6, 32'h02020202);
    c0 = irq_cnt[0]; n0 = irq_cnt[1];
    wr(3'd3, 32'h201);
    wr(3'd7, 32'h201);
    wait_irq(0, c0 + 1); wait_irq(1, n0 + 1);
    step(2);
    bad = 0;
    for (int i = 1; i < 8; i++)
      if ((acc_addr[base+i] >= 32'h3A0) == (acc_addr[base+i-1] >= 32'h3A0)) bad++;
    chk(acc_n - base == 8 && bad == 0 && acc_addr[base] < 32'h3A0, "R12 alternation", bad, 0);

    // R9 pulse width and counts
    chk(irq_max == 1, "R9 irq one cycle", irq_max, 1);
    chk(irq_cnt[0] + irq_cnt[1] == 10, "R9 irq count", irq_cnt[0] + irq_cnt[1], 10);

    $display("  CHECKS %0d ERRORS %0d", chk_n, fail_n);
    $finish;
  end
endmodule